// File: doc/BRIEF.md
# Linked Descriptor Register Loader

This block configures a transfer channel from a chain of descriptors held in memory. On a kick it reads a header word at the given byte address. Each assigned bit set in the header selects one channel register. The loader reads one payload word for each such bit from the addresses that follow the header, and writes it to the channel in ascending bit order. When every selected register has been written, the loader pulses the channel start strobe. It then waits for the channel's done input.

If the descriptor loaded a link word and bit 0 of that word is set, the loader fetches the next descriptor at the link address, with its two low bits cleared, once the channel reports done. Otherwise the chain ends. A failed memory read aborts the load, raises an error flag and does not start the channel.

Memory reads use a request channel (valid/ready) and a response that comes back in a later cycle. The loader keeps only one read outstanding and always accepts the response. Register writes use a valid/ready channel. In both channels, the loader holds a request, including its address or index and data, until the cycle in which ready is high. Kick, start, done, busy and the error flag are plain level or strobe pins.

Top module: `desc_loader`

## Requirements
- R1: After reset the loader is idle: busy, rd_req_valid, wr_valid, ch_start and fetch_err are all 0.
- R2: A kick while idle fetches the header at kick_addr. A kick while busy has no effect.
- R3: The assigned selector bits are 2 to 12, 14, 19, 20 and 29 to 31. Each one set in the header consumes one payload word. The words are read at header address + 4, + 8 and so on, with no gaps. Each word is written with wr_idx equal to its bit number, lowest bit first.
- R4: Header bits 1, 13, 15 to 18 and 21 to 28 are ignored. They consume no payload word and cause no write.
- R5: Header bit 0 (clear) causes one write with wr_idx 0 and wr_data 0 before any payload write. It consumes no payload word.
- R6: ch_start is a one-cycle pulse, issued only after the last selected write has been accepted. A header with no selected bits starts the channel with no writes.
- R7: After ch_done, if the link word (bit 30) was loaded in this descriptor with its bit 0 set, the next header is fetched at that word with bits 1:0 cleared. Otherwise the loader goes idle. ch_done is ignored when no transfer is running.
- R8: A read response with rd_rsp_err set stops loading. fetch_err becomes 1, busy drops, there are no more reads or writes and no start. The next accepted kick clears fetch_err.
- R9: While rd_req_ready is low, rd_req_valid and rd_req_addr hold. While wr_ready is low, wr_valid, wr_idx and wr_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick | input | 1 | Start fetching a chain |
| kick_addr | input | AW | Byte address of the first header |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | AW | Byte address of the word to read |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 32 | Read response word |
| rd_rsp_err | input | 1 | Read response is an error |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Channel accepts the write |
| wr_idx | output | 5 | Selector bit number of the register |
| wr_data | output | 32 | Register value |
| ch_start | output | 1 | Channel enable strobe |
| ch_done | input | 1 | Channel transfer finished |
| busy | output | 1 | Loader is not idle |
| fetch_err | output | 1 | Last load aborted on a read error |

## Verification
The header request appears in the cycle after the kick edge. Each payload write appears in the cycle after its read response. ch_start comes in the second cycle after the last write handshake. After a done with the link enable set, the next header request comes in the following cycle. The bench does not sample at those fixed offsets. It logs every read and write handshake at the clock edge, waits on a counted start pulse or on busy falling under a timeout, and then compares the logs with the expected order and addresses. Level results such as busy and fetch_err are sampled at the falling edge after the edge that updates them. The checker asserts the back-pressure hold rules and the start pulse ordering cycle by cycle.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SEL_W     = $clog2(WORD_W);
  localparam int unsigned CLEAR_BIT = 0;
  localparam int unsigned LINK_BIT  = 30;
  // selector bits that consume a payload word
  localparam logic [WORD_W-1:0] LOAD_MASK = 32'hE018_5FFC;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR_REQ, S_HDR_WAIT, S_CLR_WR,
    S_PAY_REQ, S_PAY_WAIT, S_PAY_WR, S_START, S_RUN
  } ld_state_e;
endpackage

// File: rtl/dl_low_pick.sv
module dl_low_pick #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/dl_word_ptr.sv
module dl_word_ptr #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (adv)  addr <= addr + AW'(STEP);
  end
endmodule

// File: rtl/desc_loader.sv
module desc_loader
  import dl_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [AW-1:0]     kick_addr,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [WORD_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [SEL_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data,
  output logic              ch_start,
  input  logic              ch_done,
  output logic              busy,
  output logic              fetch_err
);
  localparam int unsigned BYTES = WORD_W / 8;
  localparam logic [AW-1:0] ALIGN = ~AW'(BYTES - 1);

  ld_state_e          st;
  logic [WORD_W-1:0]  pend, link_q, data_q;
  logic [SEL_W-1:0]   cur_idx, pick_idx;
  logic               pick_any, err_q;
  logic               ptr_load, ptr_adv;
  logic [AW-1:0]      ptr, ptr_load_val, link_target;

  dl_low_pick #(.W(WORD_W)) u_pick (
    .vec(pend), .any(pick_any), .idx(pick_idx)
  );

  assign link_target  = link_q[AW-1:0] & ALIGN;
  assign ptr_load     = (st == S_IDLE && kick) || (st == S_RUN && ch_done && link_q[0]);
  assign ptr_load_val = (st == S_IDLE) ? kick_addr : link_target;
  assign ptr_adv      = rd_rsp_valid && !rd_rsp_err &&
                        (st == S_HDR_WAIT || st == S_PAY_WAIT);

  dl_word_ptr #(.AW(AW), .STEP(BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(ptr_load_val),
    .adv(ptr_adv), .addr(ptr)
  );

  assign rd_req_valid = (st == S_HDR_REQ) || (st == S_PAY_REQ && pick_any);
  assign rd_req_addr  = ptr;
  assign wr_valid     = (st == S_CLR_WR) || (st == S_PAY_WR);
  assign wr_idx       = (st == S_CLR_WR) ? SEL_W'(CLEAR_BIT) : cur_idx;
  assign wr_data      = (st == S_CLR_WR) ? '0 : data_q;
  assign ch_start     = (st == S_START);
  assign busy         = (st != S_IDLE);
  assign fetch_err    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pend    <= '0;
      link_q  <= '0;
      data_q  <= '0;
      cur_idx <= '0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (kick) begin
          err_q <= 1'b0;
          st    <= S_HDR_REQ;
        end
        S_HDR_REQ: if (rd_req_ready) st <= S_HDR_WAIT;
        S_HDR_WAIT: if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else begin
            pend   <= rd_rsp_data & LOAD_MASK;
            link_q <= '0;
            st     <= rd_rsp_data[CLEAR_BIT] ? S_CLR_WR : S_PAY_REQ;
          end
        end
        S_CLR_WR: if (wr_ready) st <= S_PAY_REQ;
        S_PAY_REQ: begin
          if (!pick_any)         st <= S_START;
          else if (rd_req_ready) st <= S_PAY_WAIT;
        end
        S_PAY_WAIT: if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else begin
            data_q  <= rd_rsp_data;
            cur_idx <= pick_idx;
            st      <= S_PAY_WR;
          end
        end
        S_PAY_WR: if (wr_ready) begin
          pend[cur_idx] <= 1'b0;
          if (cur_idx == SEL_W'(LINK_BIT)) link_q <= data_q;
          st <= S_PAY_REQ;
        end
        S_START: st <= S_RUN;
        S_RUN: if (ch_done) st <= link_q[0] ? S_HDR_REQ : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_loader_chk.sv
module desc_loader_chk
  import dl_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kick,
  input logic [AW-1:0]     kick_addr,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [AW-1:0]     rd_req_addr,
  input logic              rd_rsp_valid,
  input logic [WORD_W-1:0] rd_rsp_data,
  input logic              rd_rsp_err,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [SEL_W-1:0]  wr_idx,
  input logic [WORD_W-1:0] wr_data,
  input logic              ch_start,
  input logic              ch_done,
  input logic              busy,
  input logic              fetch_err
);
  logic [WORD_W-1:0] legal_idx;
  assign legal_idx = LOAD_MASK | (WORD_W'(1) << CLEAR_BIT);

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_idx) && $stable(wr_data));
  assert_wr_idx_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> legal_idx[wr_idx]);
  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start |=> !ch_start);
  assert_start_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start |-> !wr_valid && !rd_req_valid);
  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_err) |-> !busy && !ch_start);
  assert_one_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid));
endmodule

bind desc_loader desc_loader_chk #(.AW(AW)) u_chk (.*);

// File: tb/desc_loader_bench.sv
module desc_loader_bench;
  localparam logic [31:0] ASSIGNED = 32'hE018_5FFC;
  localparam int NV = 6;
  // {header, expected write count}
  localparam logic [63:0] VEC [NV] = '{
    {32'hE018_5FFD, 32'd18},
    {32'h0000_0000, 32'd0},
    {32'h0000_2002, 32'd0},
    {32'h0010_0051, 32'd4},
    {32'h8000_0100, 32'd2},
    {32'h1FE0_A000, 32'd0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, kick = 1'b0, ch_done = 1'b0, stall_en = 1'b0;
  logic [31:0] kick_addr = '0;
  logic rd_req_valid, rd_req_ready, wr_valid, wr_ready, ch_start, busy, fetch_err;
  logic [31:0] rd_req_addr, wr_data;
  logic [4:0]  wr_idx;
  logic rd_rsp_valid = 1'b0, rd_rsp_err = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic [7:0]  cyc = '0;

  logic [31:0] mem [128];
  int err_word = -1;
  logic [31:0] rd_log [64];
  logic [4:0]  wl_idx [64];
  logic [31:0] wl_dat [64];
  int n_rd = 0, n_wr = 0, n_start = 0;
  logic [4:0]  ex_idx [64];
  logic [31:0] ex_dat [64];
  int ex_n;
  int n_chk = 0, n_err = 0;

  assign rd_req_ready = !stall_en || (cyc[1:0] != 2'd0);
  assign wr_ready     = !stall_en || cyc[1];

  desc_loader u_desc_loader (
    .clk(clk), .rst_n(rst_n), .kick(kick), .kick_addr(kick_addr),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
    .ch_start(ch_start), .ch_done(ch_done), .busy(busy), .fetch_err(fetch_err)
  );

  // memory model and handshake logger
  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (rd_req_valid && rd_req_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem[rd_req_addr[8:2]];
      rd_rsp_err   <= (int'(rd_req_addr[8:2]) == err_word);
      rd_log[n_rd[5:0]] <= rd_req_addr;
      n_rd <= n_rd + 1;
    end else begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_err   <= 1'b0;
    end
    if (wr_valid && wr_ready) begin
      wl_idx[n_wr[5:0]] <= wr_idx;
      wl_dat[n_wr[5:0]] <= wr_data;
      n_wr <= n_wr + 1;
    end
    if (ch_start) n_start <= n_start + 1;
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL all: watchdog expired actual=running expected=finished");
    report();
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pdata(input logic [7:0] tag, input int b);
    return {8'hC5, tag, 3'b000, 5'(b), 8'h10};
  endfunction

  task automatic build(input int wb, input logic [31:0] hdr, input logic [7:0] tag);
    int k = 1;
    ex_n = 0;
    mem[wb] = hdr;
    if (hdr[0]) begin ex_idx[0] = 5'd0; ex_dat[0] = '0; ex_n = 1; end
    for (int b = 1; b < 32; b++) begin
      if (hdr[b] && ASSIGNED[b]) begin
        mem[wb + k] = pdata(tag, b);
        ex_idx[ex_n] = 5'(b);
        ex_dat[ex_n] = mem[wb + k];
        ex_n++; k++;
      end
    end
  endtask

  task automatic pulse_kick(input logic [31:0] a);
    @(negedge clk); kick = 1'b1; kick_addr = a;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); ch_done = 1'b1;
    @(negedge clk); ch_done = 1'b0;
  endtask

  task automatic wait_start(input int b_st, input string req);
    int t = 0;
    while (n_start == b_st && t < 3000) begin @(negedge clk); t++; end
    check(n_start == b_st + 1, req, "start pulse count", 32'(n_start - b_st), 32'd1);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic cmp_writes(input int b_wr, input string req);
    bit ok = (n_wr - b_wr == ex_n);
    int bad = -1;
    for (int i = 0; i < ex_n && ok; i++) begin
      if (wl_idx[(b_wr + i) % 64] != ex_idx[i] || wl_dat[(b_wr + i) % 64] != ex_dat[i]) begin
        ok = 1'b0; bad = i;
      end
    end
    if (bad >= 0)
      check(1'b0, req, "write entry idx/data", {wl_idx[(b_wr + bad) % 64], wl_dat[(b_wr + bad) % 64][26:0]},
            {ex_idx[bad], ex_dat[bad][26:0]});
    else
      check(ok, req, "write count", 32'(n_wr - b_wr), 32'(ex_n));
  endtask

  initial begin
    int b_rd, b_wr, b_st;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !rd_req_valid && !wr_valid && !ch_start && !fetch_err, "R1",
          "idle outputs", {27'd0, busy, rd_req_valid, wr_valid, ch_start, fetch_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of headers: R3, R4, R5, R6; stalled entries exercise R9
    for (int v = 0; v < NV; v++) begin
      stall_en = v[0];
      build(0, VEC[v][63:32], 8'(v));
      check(ex_n == int'(VEC[v][31:0]), "R3", "table write count", 32'(ex_n), VEC[v][31:0]);
      b_rd = n_rd; b_wr = n_wr; b_st = n_start;
      pulse_kick(32'h0);
      wait_start(b_st, "R6");
      cmp_writes(b_wr, v[0] ? "R9" : "R3");
      check(n_rd - b_rd == ex_n - int'(VEC[v][32]) + 1, "R4", "words read",
            32'(n_rd - b_rd), 32'(ex_n - int'(VEC[v][32]) + 1));
      begin
        bit seq = 1'b1;
        for (int i = 0; i < n_rd - b_rd; i++)
          if (rd_log[(b_rd + i) % 64] != 32'(4 * i)) seq = 1'b0;
        check(seq, "R3", "consecutive read addresses", 32'(n_rd - b_rd), 32'(seq));
      end
      if (VEC[v][32]) check(wl_idx[b_wr % 64] == 5'd0 && wl_dat[b_wr % 64] == '0, "R5",
                            "clear write first", {27'd0, wl_idx[b_wr % 64]}, 32'd0);
      pulse_done();
      check(!busy, "R7", "idle after done without link", {31'd0, busy}, 32'd0);
    end
    stall_en = 1'b0;

    // R2: kick during a running transfer is ignored
    build(0, 32'h0000_0008, 8'h21);
    b_st = n_start;
    pulse_kick(32'h0);
    wait_start(b_st, "R2");
    b_rd = n_rd;
    pulse_kick(32'h40);
    repeat (3) @(negedge clk);
    check(n_rd == b_rd && busy, "R2", "reads after busy kick", 32'(n_rd - b_rd), 32'd0);
    pulse_done();
    check(!busy, "R2", "idle after done", {31'd0, busy}, 32'd0);

    // R7: done while idle is ignored
    b_rd = n_rd;
    pulse_done();
    repeat (2) @(negedge clk);
    check(!busy && n_rd == b_rd, "R7", "done while idle", 32'(n_rd - b_rd), 32'd0);

    // R7: chained descriptors
    for (int i = 0; i < 128; i++) mem[i] = '0;
    mem[0] = 32'h4000_0100; mem[1] = 32'h0000_0055; mem[2] = 32'h0000_0103;
    mem[64] = 32'h0000_0008; mem[65] = 32'h0000_0077;
    ex_n = 2; ex_idx[0] = 5'd8; ex_dat[0] = 32'h55; ex_idx[1] = 5'd30; ex_dat[1] = 32'h103;
    b_wr = n_wr; b_st = n_start;
    pulse_kick(32'h0);
    wait_start(b_st, "R7");
    cmp_writes(b_wr, "R7");
    b_rd = n_rd; b_wr = n_wr; b_st = n_start;
    pulse_done();
    check(busy, "R7", "busy after done with link", {31'd0, busy}, 32'd1);
    wait_start(b_st, "R7");
    check(rd_log[b_rd % 64] == 32'h100, "R7", "next header address", rd_log[b_rd % 64], 32'h100);
    ex_n = 1; ex_idx[0] = 5'd3; ex_dat[0] = 32'h77;
    cmp_writes(b_wr, "R7");
    pulse_done();
    check(!busy, "R7", "chain end", {31'd0, busy}, 32'd0);

    // R8: error on the second payload word
    mem[0] = 32'h0000_0030; mem[1] = 32'h1; mem[2] = 32'h2;
    err_word = 2;
    b_wr = n_wr; b_st = n_start;
    pulse_kick(32'h0);
    wait_idle();
    repeat (2) @(negedge clk);
    check(fetch_err && !busy, "R8", "error flag", {30'd0, fetch_err, busy}, 32'd2);
    check(n_start == b_st, "R8", "no start", 32'(n_start - b_st), 32'd0);
    check(n_wr - b_wr == 1, "R8", "writes before error", 32'(n_wr - b_wr), 32'd1);

    // R8: error on the header
    err_word = 0;
    b_wr = n_wr; b_st = n_start;
    pulse_kick(32'h0);
    wait_idle();
    check(fetch_err && n_wr == b_wr && n_start == b_st, "R8", "header error",
          32'(n_wr - b_wr + n_start - b_st), 32'd0);

    // R8: next kick clears the flag
    err_word = -1;
    mem[0] = 32'h0;
    b_st = n_start;
    pulse_kick(32'h0);
    check(!fetch_err, "R8", "flag cleared by kick", {31'd0, fetch_err}, 32'd0);
    wait_start(b_st, "R6");
    pulse_done();

    report();
  end
endmodule